// File: doc/BRIEF.md
# Optimistic Retransmitting Link Pair

This block carries a stream of flits across one link and uses an optimistic flow-control scheme. The sender puts a flit on the link as soon as it is offered. It does not first learn whether the far end has space. Every flit it sends stays in a small retransmit store, tagged with a wrapping sequence number, until the far end acknowledges it. The receiver has a shallow buffer and may refuse a flit. When it refuses one, it returns a negative acknowledgement, and the sender then replays from its held copies.

Recovery is go-back-N. The receiver takes only the sequence number it expects next. A refusal names that expected number, and the sender rewinds to it and resends every later held flit in order. Acknowledgements are cumulative. After a refusal the receiver drops the stale flits still in flight without answering them, and it stays in that mode until the awaited flit arrives. Both ends sit under one top level. The link and the response channel come out as ports, so their traffic can be observed.

Top module: `arq_link`

## Requirements
- R1: A flit accepted on `in_valid && in_ready` appears on the link in the next cycle, with `link_seq` equal to its acceptance count modulo 2^SEQ_W and its data unchanged. No receiver state is consulted first. The link is valid exactly when an accepted flit, a rewind, or pending held flits call for a transmission.
- R2: `in_ready` is high exactly when no negative acknowledgement (`rsp_valid && rsp_nack`) is arriving, no held flit is waiting to be resent, and fewer than WIN_DEPTH sent flits are unacknowledged. With the sink halted and an empty receiver, exactly RX_DEPTH + WIN_DEPTH flits are accepted.
- R3: A held entry is released only by an acknowledgement. An acknowledgement (`rsp_nack` = 0) for sequence s releases every held entry up to and including s.
- R4: The receiver stores only the flit whose sequence equals its expected number. Each acknowledgement carries that number, and successive acknowledgements step by one modulo 2^SEQ_W.
- R5: If the expected flit meets a full receiver buffer, the receiver answers with `rsp_nack` = 1 carrying the expected number and enters discard mode. A flit with any other number gets that same negative answer only outside discard mode. In discard mode it gets no response at all.
- R6: After a negative acknowledgement for s, the very next link cycle carries s with its original data. Without an intervening negative acknowledgement, consecutive link flits carry consecutive sequence numbers.
- R7: The output stream (`out_valid && out_ready`) equals the input stream in order, with no loss and no duplicates, across sequence wrap.
- R8: While reset is asserted, `link_valid`, `rsp_valid` and `out_valid` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Source offers a flit |
| in_data | input | DATA_W | Offered flit payload |
| in_ready | output | 1 | Sender takes the offered flit this cycle |
| link_valid | output | 1 | Link carries a flit this cycle |
| link_seq | output | SEQ_W | Sequence number of the link flit |
| link_data | output | DATA_W | Payload of the link flit |
| rsp_valid | output | 1 | Receiver response present |
| rsp_nack | output | 1 | 1 = negative acknowledgement, 0 = acknowledgement |
| rsp_seq | output | SEQ_W | Sequence number the response refers to |
| out_valid | output | 1 | Receiver buffer holds a flit for the sink |
| out_data | output | DATA_W | Oldest buffered flit |
| out_ready | input | 1 | Sink takes the flit |

## Verification
The bench keeps its own model of both ends. From the observed responses it predicts, every cycle, `in_ready`, whether the link is busy, which flit index the link must carry, and which response the receiver must give. Sink patterns of several duty cycles make the receiver buffer fill at varying moments. Each such moment is a refusal with stale flits still in flight: if the discard mode were wrong, extra or missing responses would appear. If the rewind were wrong, the link would carry the wrong sequence number or data in the cycle after the refusal. A fully halted sink checks that the window stops accepting at exactly buffer plus window depth. A design that freed entries early would take more flits than that. A design that freed them late would stall below the count or deadlock after release.

// File: rtl/arq_pkg.sv
package arq_pkg;
  typedef enum logic {
    RX_ACCEPT  = 1'b0,
    RX_DISCARD = 1'b1
  } rx_mode_e;
endpackage

// File: rtl/arq_fifo.sv
module arq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
    if (do_push && !do_pop) cnt_d = cnt_q + CW'(1);
    if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (do_push && wr_q == AW'(i)) mem_q[i] <= din;
    end
  end

  // R7: storage never holds more than its depth
  p_fifo_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/arq_tx.sv
module arq_tx #(
  parameter int DATA_W    = 8,
  parameter int SEQ_W     = 3,
  parameter int WIN_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              link_valid,
  output logic [SEQ_W-1:0]  link_seq,
  output logic [DATA_W-1:0] link_data,
  input  logic              rsp_valid,
  input  logic              rsp_nack,
  input  logic [SEQ_W-1:0]  rsp_seq
);
  localparam int IDX_W = $clog2(WIN_DEPTH);

  logic [DATA_W-1:0] hold_q [WIN_DEPTH];
  logic [SEQ_W-1:0]  base_q, base_d, next_q, next_d, ptr_q, ptr_d;
  logic [SEQ_W-1:0]  cnt, rsp_off, eff_ptr;
  logic              hit, nack_hit, ack_hit, take, resend;
  logic              lv_q, lv_d;
  logic [SEQ_W-1:0]  ls_q, ls_d;
  logic [DATA_W-1:0] ld_q, ld_d;

  assign cnt      = next_q - base_q;
  assign rsp_off  = rsp_seq - base_q;
  assign hit      = rsp_valid && (rsp_off < cnt);
  assign nack_hit = hit && rsp_nack;
  assign ack_hit  = hit && !rsp_nack;
  assign in_ready = !nack_hit && (ptr_q == next_q) && (cnt < SEQ_W'(WIN_DEPTH));
  assign take     = in_valid && in_ready;
  assign eff_ptr  = nack_hit ? rsp_seq : ptr_q;
  assign resend   = (eff_ptr != next_q);

  always_comb begin
    base_d = base_q;
    if (ack_hit)       base_d = rsp_seq + SEQ_W'(1);
    else if (nack_hit) base_d = rsp_seq;
    next_d = take ? next_q + SEQ_W'(1) : next_q;
    if (resend)    ptr_d = eff_ptr + SEQ_W'(1);
    else if (take) ptr_d = ptr_q + SEQ_W'(1);
    else           ptr_d = eff_ptr;
    lv_d = resend || take;
    ls_d = resend ? eff_ptr : next_q;
    ld_d = resend ? hold_q[eff_ptr[IDX_W-1:0]] : in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      next_q <= '0;
      ptr_q  <= '0;
      lv_q   <= 1'b0;
      ls_q   <= '0;
    end else begin
      base_q <= base_d;
      next_q <= next_d;
      ptr_q  <= ptr_d;
      lv_q   <= lv_d;
      if (lv_d) ls_q <= ls_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lv_d) ld_q <= ld_d;
    for (int i = 0; i < WIN_DEPTH; i++) begin
      if (take && next_q[IDX_W-1:0] == IDX_W'(i)) hold_q[i] <= in_data;
    end
  end

  assign link_valid = lv_q;
  assign link_seq   = ls_q;
  assign link_data  = ld_q;

  // R1: accepted flit goes out next cycle with its number and payload
  p_new_flit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (link_valid && link_seq == $past(next_q)
                                && link_data == $past(in_data)));
  // R2: unacknowledged count stays within the window
  p_window_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (next_q - base_q) <= SEQ_W'(WIN_DEPTH));
  // R3: nothing is released without a response
  p_base_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |=> $stable(base_q));
  // R6: a refusal makes the next link flit the refused one
  p_rewind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nack_hit |=> (link_valid && link_seq == $past(rsp_seq)));
endmodule

// File: rtl/arq_rx.sv
module arq_rx
  import arq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SEQ_W    = 3,
  parameter int RX_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_valid,
  input  logic [SEQ_W-1:0]  link_seq,
  input  logic [DATA_W-1:0] link_data,
  output logic              rsp_valid,
  output logic              rsp_nack,
  output logic [SEQ_W-1:0]  rsp_seq,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);
  logic [SEQ_W-1:0] exp_q, exp_d;
  rx_mode_e         mode_q, mode_d;
  logic             match, push, send_nack, buf_full, buf_empty;
  logic             rv_q, rn_q;
  logic [SEQ_W-1:0] rs_q;

  arq_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (link_data),
    .pop   (out_ready),
    .dout  (out_data),
    .full  (buf_full),
    .empty (buf_empty)
  );

  assign out_valid = !buf_empty;
  assign match     = link_valid && (link_seq == exp_q);
  assign push      = match && !buf_full;
  assign send_nack = link_valid && ((match && buf_full) ||
                                    (!match && mode_q == RX_ACCEPT));

  always_comb begin
    exp_d  = push ? exp_q + SEQ_W'(1) : exp_q;
    mode_d = mode_q;
    if (push)           mode_d = RX_ACCEPT;
    else if (send_nack) mode_d = RX_DISCARD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q  <= '0;
      mode_q <= RX_ACCEPT;
      rv_q   <= 1'b0;
      rn_q   <= 1'b0;
      rs_q   <= '0;
    end else begin
      exp_q  <= exp_d;
      mode_q <= mode_d;
      rv_q   <= push || send_nack;
      if (push || send_nack) begin
        rn_q <= send_nack;
        rs_q <= exp_q;
      end
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_nack  = rn_q;
  assign rsp_seq   = rs_q;

  // R4: an acknowledgement names the number just stored
  p_ack_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_nack) |-> (exp_q == rsp_seq + SEQ_W'(1)));
  // R5: a refusal names the still-awaited number and leaves discard mode set
  p_nack_expected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_nack) |-> (rsp_seq == exp_q && mode_q == RX_DISCARD));
endmodule

// File: rtl/arq_link.sv
module arq_link #(
  parameter int DATA_W    = 8,
  parameter int SEQ_W     = 3,
  parameter int WIN_DEPTH = 4,
  parameter int RX_DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              link_valid,
  output logic [SEQ_W-1:0]  link_seq,
  output logic [DATA_W-1:0] link_data,
  output logic              rsp_valid,
  output logic              rsp_nack,
  output logic [SEQ_W-1:0]  rsp_seq,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  arq_tx #(.DATA_W(DATA_W), .SEQ_W(SEQ_W), .WIN_DEPTH(WIN_DEPTH)) tx_i (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .link_valid (link_valid),
    .link_seq   (link_seq),
    .link_data  (link_data),
    .rsp_valid  (rsp_valid),
    .rsp_nack   (rsp_nack),
    .rsp_seq    (rsp_seq)
  );

  arq_rx #(.DATA_W(DATA_W), .SEQ_W(SEQ_W), .RX_DEPTH(RX_DEPTH)) rx_i (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .link_valid (link_valid),
    .link_seq   (link_seq),
    .link_data  (link_data),
    .rsp_valid  (rsp_valid),
    .rsp_nack   (rsp_nack),
    .rsp_seq    (rsp_seq),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready)
  );
endmodule

// File: tb/arq_link_tb_top.sv
module arq_link_tb_top;
  localparam int DW  = 8;
  localparam int SW  = 2;
  localparam int WIN = 2;
  localparam int RX  = 2;
  localparam int MOD = 1 << SW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_ready = 1'b0;
  logic          in_ready, link_valid, rsp_valid, rsp_nack, out_valid;
  logic [SW-1:0] link_seq, rsp_seq;
  logic [DW-1:0] link_data, out_data;

  always #10 clk = ~clk;

  arq_link #(.DATA_W(DW), .SEQ_W(SW), .WIN_DEPTH(WIN), .RX_DEPTH(RX)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .link_valid(link_valid), .link_seq(link_seq),
    .link_data(link_data), .rsp_valid(rsp_valid), .rsp_nack(rsp_nack),
    .rsp_seq(rsp_seq), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready)
  );

  int  errors = 0, checks = 0, cyc = 0;
  int  acc = 0, acks = 0, delivered = 0, limit = 0;
  int  last_idx = -1, nack_idx = 0, prev_idx = -1, prev_occ = 0;
  bit  exp_lv = 0, pend_nack = 0, prev_lv = 0, discard = 0;
  bit  feed_en = 0, sink_stall = 0, done = 0;
  int  per = 0, on = 0;

  function automatic logic [DW-1:0] pat(int i);
    return DW'((i * 29 + 7) % 256);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic tick();
    int  e, acks_before, sp;
    bit  lv, nack_now, exp_rv, exp_nk, match, full, pop, exp_rdy, will;
    @(negedge clk);
    cyc++;
    lv = link_valid;
    chk(lv == exp_lv, pend_nack ? "R6" : "R1", "link_valid", int'(lv), int'(exp_lv));
    e = -1;
    if (lv) begin
      e = pend_nack ? nack_idx : last_idx + 1;
      chk(int'(link_seq) == e % MOD, pend_nack ? "R6" : "R1", "link_seq",
          int'(link_seq), e % MOD);
      chk(link_data == pat(e), pend_nack ? "R6" : "R1", "link_data",
          int'(link_data), int'(pat(e)));
      last_idx = e;
    end
    // receiver model: flit seen last tick was judged at the edge just past
    acks_before = acks;
    exp_rv = 0; exp_nk = 0;
    if (prev_lv) begin
      match = (prev_idx == acks);
      full  = (prev_occ >= RX);
      if (match && !full) exp_rv = 1;
      else if ((match && full) || (!match && !discard)) begin
        exp_rv = 1; exp_nk = 1;
      end
    end
    chk(rsp_valid == exp_rv, "R5", "rsp_valid", int'(rsp_valid), int'(exp_rv));
    if (exp_rv && rsp_valid)
      chk(rsp_nack == exp_nk, exp_nk ? "R5" : "R4", "rsp_nack",
          int'(rsp_nack), int'(exp_nk));
    if (rsp_valid)
      chk(int'(rsp_seq) == acks % MOD, "R4", "rsp_seq", int'(rsp_seq), acks % MOD);
    if (exp_rv) discard = exp_nk;
    nack_now = rsp_valid && rsp_nack;
    if (nack_now) nack_idx = acks;
    if (rsp_valid && !rsp_nack) acks++;
    // sink
    out_ready = sink_stall ? 1'b0 : ((per == 0) ? 1'b1 : ((cyc % per) < on));
    pop = out_valid && out_ready;
    if (pop) chk(out_data == pat(delivered), "R7", "out_data",
                 int'(out_data), int'(pat(delivered)));
    prev_occ = acks - delivered;
    if (pop) delivered++;
    // sender acceptance model
    exp_rdy = !nack_now && ((acc - acks_before) < WIN) && (!lv || last_idx + 1 == acc);
    chk(in_ready == exp_rdy, "R2", "in_ready", int'(in_ready), int'(exp_rdy));
    in_valid = feed_en && (acc < limit);
    in_data  = pat(acc);
    will = in_valid && in_ready;
    sp = lv ? last_idx + 1 : acc;
    if (will) acc++;
    exp_lv    = nack_now || (sp < acc);
    prev_lv   = lv;
    prev_idx  = e;
    pend_nack = nack_now;
  endtask

  task automatic drain();
    int guard = 0;
    feed_en = 0; sink_stall = 0; per = 0;
    while (!(delivered == acc && acks == acc) && guard < 1000) begin
      tick(); guard++;
    end
    chk(guard < 1000, "R7", "drain completes", guard, 0);
    repeat (3) tick();
  endtask

  task automatic run(int add, int p, int o);
    int guard = 0;
    per = p; on = o; sink_stall = 0;
    limit = acc + add; feed_en = 1;
    while (acc < limit && guard < 2000) begin
      tick(); guard++;
    end
    chk(acc == limit, "R7", "all offered flits accepted", acc, limit);
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int start;
    repeat (3) @(negedge clk);
    // R8: reset values
    chk(link_valid == 1'b0, "R8", "link_valid in reset", int'(link_valid), 0);
    chk(rsp_valid == 1'b0, "R8", "rsp_valid in reset", int'(rsp_valid), 0);
    chk(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R8", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    repeat (3) tick();

    run(30, 0, 0);
    for (int p = 2; p <= 4; p++)
      for (int o = 1; o < p; o++)
        run(16, p, o);

    // halted sink: window and receiver fill, then nothing more
    start = acc;
    sink_stall = 1; per = 0;
    limit = acc + 10; feed_en = 1;
    repeat (40) tick();
    chk(acc - start == RX + WIN, "R2", "accepted with halted sink", acc - start, RX + WIN);
    chk(acc - acks == WIN, "R3", "held unacknowledged flits", acc - acks, WIN);
    chk(in_ready == 1'b0, "R3", "in_ready with full window", int'(in_ready), 0);
    sink_stall = 0;
    begin
      int guard = 0;
      while (acc < limit && guard < 2000) begin tick(); guard++; end
    end
    chk(acc == limit, "R3", "acceptance resumes after acks", acc, limit);
    drain();

    run(20, 5, 1);
    chk(delivered == acc, "R7", "total delivered", delivered, acc);
    chk(out_valid == 1'b0, "R7", "no leftover flit", int'(out_valid), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule